// File: doc/BRIEF.md
# Three-Requester Non-Preemptive Priority Arbiter

This block hands a single shared resource to one of three requesters at a time. Each requester raises its own request line and is served when its own grant line comes up. When no one owns the resource, the arbiter picks the most important pending request. Requester index 0 is the most important, then index 1, then index 2. The winner keeps the resource for as long as it keeps its request high. A more important request that arrives meanwhile does not take the resource away.

The arbiter is a Moore machine with four states: one idle state and one ownership state per requester. The grant lines are registered and decoded only from the state. When the owner drops its request, the arbiter goes back to idle for one cycle and then arbitrates again. Every change of owner therefore passes through one cycle with no grant. Reset is synchronous and active high.

Top module: `shared_grant_arbiter`

## Requirements
- R1: While `rst` is high at a rising clock edge, all bits of `gnt_o` are 0 after that edge, whatever the requests are.
- R2: At most one bit of `gnt_o` is 1 in any cycle.
- R3: When no grant is active and `req_i[0]` is 1 at a clock edge, `gnt_o` becomes 3'b001 after that edge, whatever the other requests are.
- R4: When no grant is active, `req_i[0]` is 0 and `req_i[1]` is 1 at a clock edge, `gnt_o` becomes 3'b010 after that edge.
- R5: When no grant is active and `req_i` is 3'b100 at a clock edge, `gnt_o` becomes 3'b100 after that edge.
- R6: While the owner's request bit stays 1, its grant stays unchanged. This holds even when a lower-index request is also high (non-preemptive).
- R7: When a grant is active and the owner's request bit is 0 at a clock edge, `gnt_o` is all 0 after that edge. A new owner can be granted no earlier than the following edge.
- R8: When no grant is active and `req_i` is all 0 at a clock edge, `gnt_o` stays all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| req_i | input | 3 | Request lines; bit i belongs to requester i, bit 0 most important |
| gnt_o | output | 3 | Registered one-hot grant lines; bit i belongs to requester i |

## Verification
The properties assume that `req_i` carries known values at every sampling edge once reset is released. They also assume each requester holds a steady level between edges. This lets "no grant active" stand for the idle state, with nothing changing in the middle of a cycle. The stimulus changes `req_i` only on falling edges, and always as a whole vector. It keeps the requests asserted during reset so that the clearing is visible. It walks every request pattern from idle, and it raises lower-index requests while an owner holds the resource to exercise the non-preemptive hold.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_REQ = 3;

  // decision taken by the owner FSM in one cycle
  typedef enum logic [1:0] {
    ACT_STAY_IDLE = 2'd0,
    ACT_CLAIM     = 2'd1,
    ACT_HOLD      = 2'd2,
    ACT_RELEASE   = 2'd3
  } arb_act_t;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  // seen[i] is high when some bit below i is requesting
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pick_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req_i[i];
  end
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import arb_pkg::*;
#(
  parameter int N  = 3,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  pick_i,
  output logic          busy_d,
  output logic [OW-1:0] owner_d
);
  logic          busy_q;
  logic [OW-1:0] owner_q;
  logic [OW-1:0] pick_idx;
  arb_act_t      act;

  // one-hot pick to index
  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_i[i]) pick_idx = OW'(i);
    end
  end

  always_comb begin
    if (!busy_q) act = (|req_i) ? ACT_CLAIM : ACT_STAY_IDLE;
    else         act = req_i[owner_q] ? ACT_HOLD : ACT_RELEASE;
  end

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    case (act)
      ACT_CLAIM:   begin busy_d = 1'b1; owner_d = pick_idx; end
      ACT_RELEASE: begin busy_d = 1'b0; owner_d = '0;       end
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
    end
  end
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
  parameter int N  = 3,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_d,
  input  logic [OW-1:0] owner_d,
  output logic [N-1:0]  gnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_gnt
    always_ff @(posedge clk) begin
      if (rst) gnt_o[i] <= 1'b0;
      else     gnt_o[i] <= busy_d && (owner_d == OW'(i));
    end
  end
endmodule

// File: rtl/shared_grant_arbiter.sv
module shared_grant_arbiter #(
  parameter int N_REQ = arb_pkg::NUM_REQ
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o
);
  localparam int OWNER_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0]   pick;
  logic               busy_d;
  logic [OWNER_W-1:0] owner_d;

  arb_prio_pick #(.N(N_REQ)) u_pick (
    .req_i  (req_i),
    .pick_o (pick)
  );

  arb_owner_fsm #(.N(N_REQ), .OW(OWNER_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .pick_i  (pick),
    .busy_d  (busy_d),
    .owner_d (owner_d)
  );

  arb_grant_reg #(.N(N_REQ), .OW(OWNER_W)) u_gnt (
    .clk     (clk),
    .rst     (rst),
    .busy_d  (busy_d),
    .owner_d (owner_d),
    .gnt_o   (gnt_o)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_i,
  input logic [N-1:0] gnt_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> gnt_o == '0);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  // R3
  first_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && req_i[0]) |=> gnt_o == N'(1));

  // R4
  second_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && !req_i[0] && req_i[1]) |=> gnt_o == N'(2));

  // R5
  third_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && !req_i[0] && !req_i[1] && req_i[2]) |=> gnt_o == N'(4));

  // R6
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(gnt_o & req_i)) |=> $stable(gnt_o));

  // R7
  owner_release_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && !(|(gnt_o & req_i))) |=> gnt_o == '0);

  // R8
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && req_i == '0) |=> gnt_o == '0);
endmodule

bind shared_grant_arbiter arb_chk #(.N(N_REQ)) u_arb_chk (
  .clk   (clk),
  .rst   (rst),
  .req_i (req_i),
  .gnt_o (gnt_o)
);

// File: tb/tb_shared_grant_arbiter.sv
`timescale 1ns/1ps
module tb_shared_grant_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req_i = 3'b111;
  logic [2:0] gnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] model_gnt = 3'b000;

  shared_grant_arbiter dut (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .gnt_o (gnt_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: drive a request vector and queue the expected grant
  task automatic step(input logic [2:0] r);
    logic [2:0] nxt;
    string      tag;
    @(negedge clk);
    req_i = r;
    if (model_gnt == 3'b000) begin
      if (r[0])      begin nxt = 3'b001; tag = "R3"; end
      else if (r[1]) begin nxt = 3'b010; tag = "R4"; end
      else if (r[2]) begin nxt = 3'b100; tag = "R5"; end
      else           begin nxt = 3'b000; tag = "R8"; end
    end else if (|(model_gnt & r)) begin
      nxt = model_gnt; tag = "R6";
    end else begin
      nxt = 3'b000; tag = "R7";
    end
    model_gnt = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // monitor: compare just after each edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, gnt_o, e);
      checks++;
      if (!$onehot0(gnt_o)) begin
        errors++;
        $display("FAIL R2: gnt_o=%b expected at most one bit set", gnt_o);
      end
    end
  end

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset with all requests high
    repeat (3) @(posedge clk);
    #1 check("R1", gnt_o, 3'b000);
    @(negedge clk);
    rst   = 1'b0;
    req_i = 3'b000;

    step(3'b000);   // R8
    step(3'b111);   // R3
    step(3'b111);   // R6
    step(3'b110);   // R7
    step(3'b110);   // R4
    step(3'b011);   // R6 with a higher request pending
    step(3'b001);   // R7 (index 0 waits one idle cycle)
    step(3'b001);   // R3
    step(3'b000);   // R7
    step(3'b100);   // R5
    step(3'b111);   // R6 non-preemptive
    step(3'b011);   // R7
    step(3'b011);   // R3
    step(3'b010);   // R7
    step(3'b010);   // R4
    step(3'b010);   // R6
    step(3'b000);   // R7
    step(3'b000);   // R8

    // every pattern from idle, then release
    for (int p = 0; p < 8; p++) begin
      step(3'(p));
      step(3'b000);
    end

    // R1: reset while a grant is held
    step(3'b100);
    step(3'b100);
    @(negedge clk);
    wait (exp_q.size() == 0);
    rst = 1'b1;
    @(posedge clk);
    #1 check("R1", gnt_o, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    req_i = 3'b000;
    model_gnt = 3'b000;
    step(3'b010);   // R4 after reset
    step(3'b000);   // R7

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    finish_run();
  end
endmodule